// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Pair

This block produces two programmable fill-level warnings for a FIFO whose write and read sides run on unrelated clocks. Both pointers arrive in Gray code. The almost-empty warning is formed in the read clock domain and is asserted (driven LOW) while the stored word count is at or below an empty-side offset X. The almost-full warning is formed in the write clock domain and is asserted (LOW) while the word count has come within Y words of the depth. The offset is counted in a different direction on each side.

The read pointer counts every word taken out of the storage array. This includes a word that has only been moved into the FIFO output register, so such a word no longer counts toward the fill level. The pointer from the other domain passes through one capture flop, and the flag register follows that flop. A pointer change on the far side therefore shows on the flag at the second rising edge of the flag's own clock. A pointer change on the flag's own side shows at the next edge.

Both offsets reset to a parameterised preset value. The write side can reload either offset through a parallel load strobe. A load value that is not below the depth is refused. The offsets are quasi-static. They are meant to be loaded while the FIFO is idle, and the read domain uses the empty-side offset directly.

Top module: `fifo_level_flags`

## Requirements
- R1: While the resets are held and right after they are released, ae_n is LOW, af_n is HIGH and both offsets hold the PRESET parameter value.
- R2: Once its inputs have settled, ae_n is LOW when the word count (write pointer minus read pointer, where the read pointer already includes any word moved into the output register) is X or less, and HIGH when the count is X+1 or more.
- R3: Once its inputs have settled, af_n is LOW when the word count is at least DEPTH−Y, and HIGH when it is DEPTH−(Y+1) or less.
- R4: The word count is taken modulo 2^(ADDR_W+1), so the flags stay correct as the pointers wrap past their maximum value.
- R5: After a write that raises the count from X to X+1, ae_n is still LOW after the first rising read-clock edge and is HIGH after the second.
- R6: After a read that lowers the count from DEPTH−Y to DEPTH−Y−1, af_n is still LOW after the first rising write-clock edge and is HIGH after the second.
- R7: A change of a flag's own-side pointer is reflected on that flag at the next rising edge of its own clock.
- R8: A write-clock edge with ld_en=1 loads ld_data into X when ld_sel=0, or into Y when ld_sel=1, and the flags then use the new offset.
- R9: A load whose ld_data is DEPTH or more leaves both offsets unchanged.
- R10: Both pointers are ADDR_W+1-bit Gray codes, where gray = bin ^ (bin >> 1), and each changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low, asynchronous |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low, asynchronous |
| wptr_gray | input | ADDR_W+1 | Write pointer in Gray code, write domain |
| rptr_gray | input | ADDR_W+1 | Read pointer in Gray code, read domain; counts words moved to the output register |
| ld_en | input | 1 | Offset load strobe, write domain |
| ld_sel | input | 1 | Load target: 0 selects X (empty side), 1 selects Y (full side) |
| ld_data | input | ADDR_W+1 | Offset value to load; values of DEPTH or more are refused |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |
| af_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
A wrong synchroniser or Gray decode shows as a flag that holds the wrong level at one count and offset after the pointers have settled. The bench sweeps every count from empty to full and back, under several offsets, so a fault of this kind shows within about five clock cycles of the step that reaches the bad count. An extra or missing register stage does not change any settled level, so it is caught only by sampling between edges right after a pointer step. The almost-empty path is observed between read-clock edges and the almost-full path between write-clock edges. A faulty offset register shows as a threshold that has moved to another count in the next sweep.

// File: rtl/flag_pkg.sv
package flag_pkg;
    typedef enum logic {
        TGT_EMPTY_SIDE = 1'b0,
        TGT_FULL_SIDE  = 1'b1
    } load_tgt_e;
endpackage

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
    parameter int W = 4
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/offset_regs.sv
module offset_regs
    import flag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PRESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [ADDR_W:0]   ld_data,
    output logic [ADDR_W-1:0] x_off,
    output logic [ADDR_W-1:0] y_off
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] x;
        logic [ADDR_W-1:0] y;
    } off_t;

    off_t st_d, st_q;
    load_tgt_e tgt;

    assign tgt = load_tgt_e'(ld_sel);

    always_comb begin
        st_d = st_q;
        if (ld_en && (ld_data < DEPTH_L)) begin
            if (tgt == TGT_EMPTY_SIDE) st_d.x = ld_data[ADDR_W-1:0];
            else                       st_d.y = ld_data[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.x <= ADDR_W'(PRESET);
            st_q.y <= ADDR_W'(PRESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign x_off = st_q.x;
    assign y_off = st_q.y;
endmodule

// File: rtl/level_flag.sv
module level_flag #(
    parameter int ADDR_W  = 4,
    parameter bit IS_FULL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   far_gray,
    input  logic [ADDR_W:0]   near_gray,
    input  logic [ADDR_W-1:0] offset,
    output logic              flag_n
);
    localparam int W = ADDR_W + 1;
    localparam logic [W:0] DEPTH_L = {2'b01, {ADDR_W{1'b0}}};
    localparam logic FLAG_RST = IS_FULL;

    typedef struct packed {
        logic [W-1:0] sync;
        logic         flag_n;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] far_bin, near_bin, count;
    logic         level_ok;

    gray_to_bin #(.W(W)) u_far  (.gray(st_q.sync), .bin(far_bin));
    gray_to_bin #(.W(W)) u_near (.gray(near_gray), .bin(near_bin));

    if (IS_FULL) begin : g_full
        logic [W:0] sum;
        assign count    = near_bin - far_bin;
        assign sum      = {1'b0, count} + {2'b00, offset};
        assign level_ok = (sum < DEPTH_L);
    end else begin : g_empty
        assign count    = far_bin - near_bin;
        assign level_ok = (count > {1'b0, offset});
    end

    always_comb begin
        st_d        = st_q;
        st_d.sync   = far_gray;
        st_d.flag_n = level_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync   <= '0;
            st_q.flag_n <= FLAG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_n = st_q.flag_n;
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
    parameter int ADDR_W = 10,
    parameter int PRESET = 8
) (
    input  logic            wclk,
    input  logic            wrst_n,
    input  logic            rclk,
    input  logic            rrst_n,
    input  logic [ADDR_W:0] wptr_gray,
    input  logic [ADDR_W:0] rptr_gray,
    input  logic            ld_en,
    input  logic            ld_sel,
    input  logic [ADDR_W:0] ld_data,
    output logic            ae_n,
    output logic            af_n
);
    logic [ADDR_W-1:0] x_off;
    logic [ADDR_W-1:0] y_off;

    offset_regs #(.ADDR_W(ADDR_W), .PRESET(PRESET)) u_off (
        .clk    (wclk),
        .rst_n  (wrst_n),
        .ld_en  (ld_en),
        .ld_sel (ld_sel),
        .ld_data(ld_data),
        .x_off  (x_off),
        .y_off  (y_off)
    );

    level_flag #(.ADDR_W(ADDR_W), .IS_FULL(1'b0)) u_ae (
        .clk      (rclk),
        .rst_n    (rrst_n),
        .far_gray (wptr_gray),
        .near_gray(rptr_gray),
        .offset   (x_off),
        .flag_n   (ae_n)
    );

    level_flag #(.ADDR_W(ADDR_W), .IS_FULL(1'b1)) u_af (
        .clk      (wclk),
        .rst_n    (wrst_n),
        .far_gray (rptr_gray),
        .near_gray(wptr_gray),
        .offset   (y_off),
        .flag_n   (af_n)
    );
endmodule

// File: rtl/level_flags_chk.sv
module level_flags_chk #(
    parameter int ADDR_W = 10
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              rclk,
    input logic              rrst_n,
    input logic [ADDR_W:0]   wptr_gray,
    input logic [ADDR_W:0]   rptr_gray,
    input logic              ld_en,
    input logic              ld_sel,
    input logic [ADDR_W:0]   ld_data,
    input logic [ADDR_W-1:0] x_off,
    input logic [ADDR_W-1:0] y_off,
    input logic              ae_n,
    input logic              af_n
);
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(1 << ADDR_W);

    // R2: with far pointer, near pointer and offset unchanged, ae_n holds
    assert_ae_steady_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
        ($past($stable(wptr_gray)) && $stable(rptr_gray) && $stable(x_off))
        |=> $stable(ae_n));

    // R3: same for the full-side flag in the write domain
    assert_af_steady_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
        ($past($stable(rptr_gray)) && $stable(wptr_gray) && $stable(y_off))
        |=> $stable(af_n));

    assert_wptr_gray_R10: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

    assert_rptr_gray_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

    assert_load_x_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
        (ld_en && (ld_data < DEPTH_L) && !ld_sel)
        |=> (x_off == $past(ld_data[ADDR_W-1:0])));

    assert_load_y_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
        (ld_en && (ld_data < DEPTH_L) && ld_sel)
        |=> (y_off == $past(ld_data[ADDR_W-1:0])));

    assert_load_refused_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
        (ld_en && (ld_data >= DEPTH_L))
        |=> ($stable(x_off) && $stable(y_off)));
endmodule

bind fifo_level_flags level_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wclk     (wclk),
    .wrst_n   (wrst_n),
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .wptr_gray(wptr_gray),
    .rptr_gray(rptr_gray),
    .ld_en    (ld_en),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .x_off    (x_off),
    .y_off    (y_off),
    .ae_n     (ae_n),
    .af_n     (af_n)
);

// File: tb/sim_fifo_level_flags.sv
`timescale 1ns/1ps
module sim_fifo_level_flags;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int PRE   = 3;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst_n = 1'b0, rrst_n = 1'b0;
    logic [AW:0]   wptr_gray = '0, rptr_gray = '0;
    logic          ld_en = 1'b0, ld_sel = 1'b0;
    logic [AW:0]   ld_data = '0;
    logic          ae_n, af_n;
    logic [AW:0]   wb = '0, rb = '0;
    int            errors = 0, checks = 0;
    bit            done = 1'b0;

    fifo_level_flags #(.ADDR_W(AW), .PRESET(PRE)) u0 (
        .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
        .wptr_gray(wptr_gray), .rptr_gray(rptr_gray),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .ae_n(ae_n), .af_n(af_n)
    );

    always #10 wclk = ~wclk;
    initial begin
        #5;
        forever #10 rclk = ~rclk;
    end

    function automatic logic [AW:0] to_gray(logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_step();
        @(posedge wclk); #1;
        wb = wb + 1'b1;
        wptr_gray = to_gray(wb);
    endtask

    task automatic rd_step();
        @(posedge rclk); #1;
        rb = rb + 1'b1;
        rptr_gray = to_gray(rb);
    endtask

    task automatic load(logic sel, logic [AW:0] val);
        @(negedge wclk);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(negedge wclk);
        ld_en = 1'b0;
    endtask

    task automatic check_levels(string tag, int x, int y);
        logic [AW:0] diff;
        int cnt;
        diff = wb - rb;
        cnt  = int'(diff);
        check({tag, " R2 R4 ae_n"}, ae_n, (cnt > x));
        check({tag, " R3 R4 af_n"}, af_n, !(cnt >= DEPTH - y));
    endtask

    // full sweep: empty to full by single writes, back to empty by single reads
    task automatic sweep(string tag, int x, int y);
        #100;
        check_levels(tag, x, y);
        for (int i = 0; i < DEPTH; i++) begin
            wr_step(); #100;
            check_levels(tag, x, y);
        end
        for (int i = 0; i < DEPTH; i++) begin
            rd_step(); #100;
            check_levels(tag, x, y);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #45;
        check("R1 ae_n in reset", ae_n, 1'b0);
        check("R1 af_n in reset", af_n, 1'b1);
        wrst_n = 1'b1; rrst_n = 1'b1;
        #40;
        check("R1 ae_n after release", ae_n, 1'b0);
        check("R1 af_n after release", af_n, 1'b1);

        sweep("R1 preset", PRE, PRE);
        load(1'b0, 5'd0);  load(1'b1, 5'd0);
        sweep("R8 X0 Y0", 0, 0);
        load(1'b0, 5'd15); load(1'b1, 5'd15);
        sweep("R8 X15 Y15", 15, 15);
        load(1'b0, 5'd7);  load(1'b1, 5'd5);
        sweep("R8 X7 Y5", 7, 5);
        load(1'b0, 5'd16); load(1'b1, 5'd31);
        sweep("R9 refused", 7, 5);

        // R5: count 7 -> 8 by a write, X = 7
        for (int i = 0; i < 7; i++) wr_step();
        #100;
        check("R5 setup ae_n", ae_n, 1'b0);
        @(posedge wclk); #1; wb = wb + 1'b1; wptr_gray = to_gray(wb);
        @(posedge rclk); #2;
        check("R5 first rclk edge", ae_n, 1'b0);
        @(posedge rclk); #2;
        check("R5 second rclk edge", ae_n, 1'b1);

        // R7: own-side read 8 -> 7
        #100;
        @(posedge rclk); #1; rb = rb + 1'b1; rptr_gray = to_gray(rb);
        #2;
        check("R7 ae_n before edge", ae_n, 1'b1);
        @(posedge rclk); #2;
        check("R7 ae_n next rclk edge", ae_n, 1'b0);

        // R6: count 11 -> 10 by a read, Y = 5, DEPTH-Y = 11
        for (int i = 0; i < 4; i++) wr_step();
        #100;
        check("R6 setup af_n", af_n, 1'b0);
        @(posedge rclk); #1; rb = rb + 1'b1; rptr_gray = to_gray(rb);
        @(posedge wclk); #2;
        check("R6 first wclk edge", af_n, 1'b0);
        @(posedge wclk); #2;
        check("R6 second wclk edge", af_n, 1'b1);

        // R7: own-side write 10 -> 11
        #100;
        @(posedge wclk); #1; wb = wb + 1'b1; wptr_gray = to_gray(wb);
        #2;
        check("R7 af_n before edge", af_n, 1'b1);
        @(posedge wclk); #2;
        check("R7 af_n next wclk edge", af_n, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule